// File: doc/BRIEF.md
# Pulse-per-second time-tag phase detector

This block measures the phase of a local oscillator against a once-per-second timing pulse. The oscillator clocks a modulo counter that wraps once per second. When the timing pulse has a rising edge, the block takes a snapshot of the counter. The snapshot is read as a signed offset from the counter's zero point. That offset is then reduced to a small clamped window that a loop filter further down the chain can use.

At start-up the oscillator may be as much as half a second away from the pulse. Slewing it across that gap would take far too long. An align request is therefore stored until the next pulse edge arrives. On that edge the counter is loaded directly into phase, and that second yields no measurement. After this, each pulse edge produces a one-cycle strobe. The strobe carries an error class and an 8-bit value. A watchdog flags the loss of the pulse.

Top module: `ppsPhaseDetect`

## Requirements
- R1: The counter counts from 0 to CNT_MOD-1 and then returns to 0. After an align, a pulse that arrives exactly one counter period later reports an offset of 0. A pulse one cycle earlier reports -1, because the snapshot is taken on the last count before the wrap.
- R2: A rising edge on ppsIn that is first sampled at clock edge P raises errValid after clock edge P+3. errValid stays high for exactly one cycle.
- R3: A snapshot s with s >= CNT_MOD/2 is read as the negative offset s - CNT_MOD. A smaller snapshot is read as +s.
- R4: When the offset lies in the range -WIN to +WIN, errClass is 0 (in range) and errVal holds the offset as a two's-complement value.
- R5: When the offset is greater than +WIN, errClass is 2 (late) and errVal is +WIN. When the offset is less than -WIN, errClass is 1 (early) and errVal is -WIN.
- R6: An alignReq pulse sets alignArmed. The next pulse edge clears alignArmed and produces no errValid. That edge loads the counter so that a pulse exactly one period later reports 0.
- R7: holdover goes to 1 once more than 1.5 counter periods pass with no pulse edge. It returns to 0 on the next pulse edge.
- R8: During and right after reset, errValid, errClass, errVal, holdover and alignArmed are all 0.
- R9: If ppsIn is held high for many cycles, only one measurement is produced.
- R10: An offset of exactly +WIN counts as in range and +WIN+1 counts as late. A snapshot of exactly CNT_MOD/2 reads as -CNT_MOD/2 and is classed early.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Oscillator clock |
| rstN | input | 1 | Asynchronous active-low reset |
| ppsIn | input | 1 | Asynchronous once-per-second pulse |
| alignReq | input | 1 | Request to align the counter phase on the next pulse |
| errValid | output | 1 | One-cycle strobe for a new measurement |
| errClass | output | 2 | 0 = in range, 1 = early, 2 = late |
| errVal | output | ERR_W | Clamped signed offset in counts |
| holdover | output | 1 | The pulse has been missing for more than 1.5 periods |
| alignArmed | output | 1 | An align is waiting for the next pulse |

## Verification
The bench builds the block with CNT_MOD = 1000 and WIN = 10. The counter width and the output width stay at their defaults. With these values a full counter period takes 1000 cycles. The holdover threshold is therefore 1500 cycles. This puts wrap-around, both ends of the half-period sign split and the clamp boundaries within a few short periods. The signed 8-bit output, the 24-bit counter and the sync latency are all exercised exactly as they are at the full one-second modulus.

// File: rtl/ppsPhasePkg.sv
package ppsPhasePkg;

  typedef enum logic [1:0] {
    PH_INRANGE = 2'd0,
    PH_EARLY   = 2'd1,
    PH_LATE    = 2'd2
  } phClass_e;

  // strobes from control to datapath
  typedef struct packed {
    logic capture;   // take a snapshot of the counter
    logic align;     // load the counter into phase
    logic classify;  // turn the snapshot into an output
  } dpCtrl_t;

endpackage

// File: rtl/ppsPhaseCtrl.sv
module ppsPhaseCtrl
  import ppsPhasePkg::*;
#(
  parameter int CNT_MOD = 10_000_000
) (
  input  logic    clk,
  input  logic    rstN,
  input  logic    ppsIn,
  input  logic    alignReq,
  output dpCtrl_t ctl,
  output logic    holdover,
  output logic    alignArmed
);

  localparam int HOLD_LIM = CNT_MOD + CNT_MOD / 2;
  localparam int HOLD_W   = $clog2(HOLD_LIM + 1);

  logic syncA, syncB, syncPrev;
  logic edgePulse;
  logic [HOLD_W-1:0] holdCnt;

  // two-flop synchronizer followed by a rising-edge detector
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      syncA    <= 1'b0;
      syncB    <= 1'b0;
      syncPrev <= 1'b0;
    end else begin
      syncA    <= ppsIn;
      syncB    <= syncA;
      syncPrev <= syncB;
    end
  end

  assign edgePulse = syncB & ~syncPrev;

  assign ctl.capture = edgePulse & ~alignArmed;
  assign ctl.align   = edgePulse & alignArmed;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      ctl.classify <= 1'b0;
    end else begin
      ctl.classify <= ctl.capture;
    end
  end

  // the align request waits here until the next pulse edge
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      alignArmed <= 1'b0;
    end else if (ctl.align) begin
      alignArmed <= alignReq;
    end else if (alignReq) begin
      alignArmed <= 1'b1;
    end
  end

  // missing-pulse watchdog
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      holdCnt  <= '0;
      holdover <= 1'b0;
    end else if (edgePulse) begin
      holdCnt  <= '0;
      holdover <= 1'b0;
    end else begin
      if (holdCnt < HOLD_W'(HOLD_LIM)) holdCnt <= holdCnt + 1'b1;
      if (holdCnt == HOLD_W'(HOLD_LIM)) holdover <= 1'b1;
    end
  end

  p_strobe_excl_r6: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({ctl.capture, ctl.align, ctl.classify}));

  p_classify_single_r2: assert property (@(posedge clk) disable iff (!rstN)
    ctl.classify |=> !ctl.classify);

  p_hold_clear_r7: assert property (@(posedge clk) disable iff (!rstN)
    edgePulse |=> !holdover);

  p_align_disarm_r6: assert property (@(posedge clk) disable iff (!rstN)
    (ctl.align && !alignReq) |=> !alignArmed);

endmodule

// File: rtl/ppsPhaseDatapath.sv
module ppsPhaseDatapath
  import ppsPhasePkg::*;
#(
  parameter int CNT_MOD = 10_000_000,
  parameter int CNT_W   = 24,
  parameter int ERR_W   = 8,
  parameter int WIN     = 100
) (
  input  logic             clk,
  input  logic             rstN,
  input  dpCtrl_t          ctl,
  output logic             errValid,
  output logic [1:0]       errClass,
  output logic [ERR_W-1:0] errVal
);

  localparam int SW         = CNT_W + 1;
  localparam int HALF       = CNT_MOD / 2;
  localparam int ALIGN_LOAD = (CNT_MOD > 1) ? 1 : 0;
  localparam logic [ERR_W-1:0] POS_LIM = ERR_W'(WIN);
  localparam logic [ERR_W-1:0] NEG_LIM = ERR_W'(0) - POS_LIM;

  logic [CNT_W-1:0] cnt;
  logic [CNT_W-1:0] stamp;
  logic signed [SW-1:0] stampS, offs;
  logic isLate, isEarly;

  // one-second modulo counter; align loads it so the next pulse reads zero
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      cnt <= '0;
    end else if (ctl.align) begin
      cnt <= CNT_W'(ALIGN_LOAD);
    end else if (cnt == CNT_W'(CNT_MOD - 1)) begin
      cnt <= '0;
    end else begin
      cnt <= cnt + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      stamp <= '0;
    end else if (ctl.capture) begin
      stamp <= cnt;
    end
  end

  // signed offset, centred on the counter zero point
  always_comb begin
    stampS = signed'({1'b0, stamp});
    if (stamp >= CNT_W'(HALF)) offs = stampS - signed'(SW'(CNT_MOD));
    else                       offs = stampS;
    isLate  = offs > signed'(SW'(WIN));
    isEarly = offs < -signed'(SW'(WIN));
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      errValid <= 1'b0;
      errClass <= PH_INRANGE;
      errVal   <= '0;
    end else begin
      errValid <= ctl.classify;
      if (ctl.classify) begin
        if (isLate) begin
          errClass <= PH_LATE;
          errVal   <= POS_LIM;
        end else if (isEarly) begin
          errClass <= PH_EARLY;
          errVal   <= NEG_LIM;
        end else begin
          errClass <= PH_INRANGE;
          errVal   <= offs[ERR_W-1:0];
        end
      end
    end
  end

  p_cnt_range_r1: assert property (@(posedge clk) disable iff (!rstN)
    cnt < CNT_W'(CNT_MOD));

  p_cnt_wrap_r1: assert property (@(posedge clk) disable iff (!rstN)
    (cnt == CNT_W'(CNT_MOD - 1) && !ctl.align) |=> cnt == '0);

  p_align_load_r6: assert property (@(posedge clk) disable iff (!rstN)
    ctl.align |=> (cnt == CNT_W'(ALIGN_LOAD) && !errValid));

  p_inrange_r4: assert property (@(posedge clk) disable iff (!rstN)
    (errValid && errClass == PH_INRANGE) |->
      (int'($signed(errVal)) <= WIN && int'($signed(errVal)) >= -WIN));

  p_late_sat_r5: assert property (@(posedge clk) disable iff (!rstN)
    (errValid && errClass == PH_LATE) |-> errVal == POS_LIM);

  p_early_sat_r5: assert property (@(posedge clk) disable iff (!rstN)
    (errValid && errClass == PH_EARLY) |-> errVal == NEG_LIM);

endmodule

// File: rtl/ppsPhaseDetect.sv
module ppsPhaseDetect
  import ppsPhasePkg::*;
#(
  parameter int CNT_MOD = 10_000_000,
  parameter int CNT_W   = 24,
  parameter int ERR_W   = 8,
  parameter int WIN     = 100
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             ppsIn,
  input  logic             alignReq,
  output logic             errValid,
  output logic [1:0]       errClass,
  output logic [ERR_W-1:0] errVal,
  output logic             holdover,
  output logic             alignArmed
);

  dpCtrl_t ctl;

  ppsPhaseCtrl #(.CNT_MOD(CNT_MOD)) ctrl_i (
    .clk        (clk),
    .rstN       (rstN),
    .ppsIn      (ppsIn),
    .alignReq   (alignReq),
    .ctl        (ctl),
    .holdover   (holdover),
    .alignArmed (alignArmed)
  );

  ppsPhaseDatapath #(
    .CNT_MOD (CNT_MOD),
    .CNT_W   (CNT_W),
    .ERR_W   (ERR_W),
    .WIN     (WIN)
  ) dp_i (
    .clk      (clk),
    .rstN     (rstN),
    .ctl      (ctl),
    .errValid (errValid),
    .errClass (errClass),
    .errVal   (errVal)
  );

endmodule

// File: tb/ppsPhaseDetect_tb_top.sv
module ppsPhaseDetect_tb_top;

  localparam int M   = 1000;
  localparam int WIN = 10;
  localparam int NV  = 14;

  // offset of each pulse from its period boundary, expected value and class
  localparam int OFFS [NV] = '{0, 3, -4, 10, 11, -10, -11, 200, -200, -500, 499, -1, 1, 9};
  localparam int EVAL [NV] = '{0, 3, -4, 10, 10, -10, -10, 10, -10, -10, 10, -1, 1, 9};
  localparam int ECLS [NV] = '{0, 0,  0,  0,  2,   0,   1,  2,   1,    1,   2,  0, 0, 0};

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic ppsIn = 1'b0;
  logic alignReq = 1'b0;
  logic errValid;
  logic [1:0] errClass;
  logic [7:0] errVal;
  logic holdover;
  logic alignArmed;

  int nRun = 0;
  int nFail = 0;
  int posCnt = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;
  always @(posedge clk) posCnt <= posCnt + 1;

  ppsPhaseDetect #(.CNT_MOD(M), .CNT_W(24), .ERR_W(8), .WIN(WIN)) dut_i (
    .clk        (clk),
    .rstN       (rstN),
    .ppsIn      (ppsIn),
    .alignReq   (alignReq),
    .errValid   (errValid),
    .errClass   (errClass),
    .errVal     (errVal),
    .holdover   (holdover),
    .alignArmed (alignArmed)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    nRun++;
    if (!ok) begin
      nFail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic waitTo(input int t);
    while (posCnt < t) @(negedge clk);
  endtask

  // raise the pulse at a negedge and stop at the negedge after the fourth posedge
  task automatic riseAndWait();
    ppsIn = 1'b1;
    repeat (4) @(negedge clk);
  endtask

  int t0;
  int nValid;
  int lastVal;

  initial begin
    repeat (5) @(negedge clk);
    // R8: reset state
    chk(errValid == 0 && errClass == 0 && errVal == 0 && holdover == 0 && alignArmed == 0,
        "R8 reset state", {errValid, errClass, holdover, alignArmed}, 0);
    rstN = 1'b1;
    @(negedge clk);
    chk(errValid == 0 && alignArmed == 0, "R8 after reset", errValid, 0);

    // R6: arm an align
    alignReq = 1'b1;
    @(negedge clk);
    alignReq = 1'b0;
    @(negedge clk);
    chk(alignArmed == 1, "R6 align armed", alignArmed, 1);

    waitTo(posCnt + 20);
    t0 = posCnt;
    riseAndWait();
    chk(errValid == 0, "R6 no strobe on align edge", errValid, 0);
    ppsIn = 1'b0;
    @(negedge clk);
    chk(errValid == 0 && alignArmed == 0, "R6 disarmed, silent", {errValid, alignArmed}, 0);

    // table walk: R1 R2 R3 R4 R5 R10
    for (int i = 0; i < NV; i++) begin
      waitTo(t0 + (i + 1) * M + OFFS[i]);
      ppsIn = 1'b1;
      repeat (3) @(negedge clk);
      chk(errValid == 0, "R2 strobe not early", errValid, 0);
      @(negedge clk);
      ppsIn = 1'b0;
      chk(errValid == 1, "R2 strobe timing", errValid, 1);
      chk(int'($signed(errVal)) == EVAL[i], "R1/R3/R4/R5/R10 value",
          int'($signed(errVal)), EVAL[i]);
      chk(int'(errClass) == ECLS[i], "R4/R5/R10 class", int'(errClass), ECLS[i]);
      @(negedge clk);
      chk(errValid == 0, "R2 one-cycle strobe", errValid, 0);
    end

    // R9: a long-held pulse gives one measurement
    waitTo(t0 + (NV + 1) * M + 5);
    ppsIn = 1'b1;
    nValid = 0;
    lastVal = 0;
    for (int k = 0; k < 45; k++) begin
      @(negedge clk);
      if (k == 40) ppsIn = 1'b0;
      if (errValid) begin
        nValid++;
        lastVal = int'($signed(errVal));
      end
    end
    chk(nValid == 1, "R9 single strobe", nValid, 1);
    chk(lastVal == 5, "R9 value", lastVal, 5);

    // R7: holdover
    repeat (1400) @(negedge clk);
    chk(holdover == 0, "R7 not yet in holdover", holdover, 0);
    repeat (100) @(negedge clk);
    chk(holdover == 1, "R7 holdover set", holdover, 1);
    riseAndWait();
    ppsIn = 1'b0;
    chk(holdover == 0, "R7 holdover cleared", holdover, 0);

    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", nRun, nFail);
    $finish;
  end

  initial begin
    #400000;
    if (!done) begin
      nRun++;
      nFail++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("[TB] %0d tests run, %0d failed", nRun, nFail);
      $finish;
    end
  end

endmodule